// File: doc/BRIEF.md
# Serial NAND Command Responder

This block is the device end of a small SPI-attached NAND memory, built so that a host-side sequencer can be exercised against it. The serial lines are brought into the system clock domain by a synchronizer. Bytes are framed in SPI mode 0. The first byte of each chip-select frame is taken as an opcode, and the responder answers the feature, identification, latch, reset and array commands the way the memory would at the protocol level.

The responder keeps three feature registers: configuration at address 0xB0, status at 0xC0 and block protection at 0xA0. It also keeps a write-enable latch and an operation-in-progress flag. Array commands hold that flag for a programmable number of system clock cycles. There is no array storage, so the fail and ECC status fields always read as zero. A host driver can use the responder to exercise its polling, latch handling and protection sequences.

Top module: `spi_nand_responder`

## Requirements
- R1: Input bits are taken on the rising SCK edge and output bits change on the falling SCK edge, most significant bit first in both directions. MISO is held low while chip select is high.
- R2: Opcode 0x0F followed by a feature address returns that register on the next byte. Each further byte in the same frame returns the register's current value again. An address other than 0xB0, 0xC0 or 0xA0 reads as 0x00.
- R3: Opcode 0x1F followed by an address byte and a data byte writes the register. For configuration (0xB0) only bits 7, 6, 4 and 0 are stored and the other bits read 0. A write to status (0xC0) is ignored.
- R4: The status byte has operation in progress at bit 0, the write enable latch at bit 1, erase fail at bit 2, program fail at bit 3 and ECC state at bits 5:4. Bits 2 to 5 read 0.
- R5: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it.
- R6: Opcode 0x9F is answered with 0x00 during the dummy byte, then 0xC2, then the capacity code (0x12 when HIGH_CAP is 0, 0x22 when it is 1), then 0x00.
- R7: Opcode 0xFF clears the latch, cancels any running array operation and holds operation in progress for RESET_CYCLES clocks. It is accepted while busy.
- R8: Opcodes 0xD8 (erase), 0x10 (program execute) and 0x13 (page read) take effect after three address bytes and set operation in progress for busy_cycles clocks, or one clock if busy_cycles is zero. Erase and program are ignored unless the latch is set, and they clear the latch when they finish. Page read leaves the latch unchanged.
- R9: While operation in progress is set, every opcode except 0x0F and 0xFF is ignored.
- R10: In block protection (0xA0) only bits 7 and 5:0 are stored. Once bit 7 is set, later writes to 0xA0 are ignored until rst_n. The write that sets bit 7 is itself stored in full.
- R11: Raising chip select abandons a partial command and restarts both bit and byte counting.
- R12: After rst_n the configuration reads 0x10, block protection reads 0x38 and status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and the busy timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_cycles | input | BUSY_W | Duration of array operations in clk cycles |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A single set-feature to block protection can carry both new protection bits and the lock bit. The store and the lock therefore land on the same clock edge, and the design must let that write through. The bench writes 0xB8, reads back 0xB8, then writes 0x00 and expects 0xB8 to remain. The other collision is a reset opcode arriving while a program operation is still counting down. Reset must win over the array timer and clear the latch. The bench judges this from the status seen right after the reset and from how few polls it takes until the device is idle.

// File: rtl/spi_nand_pkg.sv
package spi_nand_pkg;

  localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
  localparam logic [7:0] OP_SET_FEAT  = 8'h1F;
  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_WRDI      = 8'h04;
  localparam logic [7:0] OP_READ_ID   = 8'h9F;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_ERASE     = 8'hD8;
  localparam logic [7:0] OP_PROG_EXEC = 8'h10;
  localparam logic [7:0] OP_PAGE_READ = 8'h13;

  localparam logic [7:0] FA_CFG  = 8'hB0;
  localparam logic [7:0] FA_STAT = 8'hC0;
  localparam logic [7:0] FA_PROT = 8'hA0;

  localparam logic [7:0] MFR_CODE = 8'hC2;
  localparam logic [7:0] CAP_1G   = 8'h12;
  localparam logic [7:0] CAP_2G   = 8'h22;

  localparam logic [7:0] CFG_WMASK  = 8'hD1;
  localparam logic [7:0] PROT_WMASK = 8'hBF;
  localparam logic [7:0] CFG_RST    = 8'h10;
  localparam logic [7:0] PROT_RST   = 8'h38;
  localparam int         PROT_LOCK  = 7;

  // status layout: [5:4] ecc, [3] program fail, [2] erase fail, [1] latch, [0] busy
  function automatic logic [7:0] pack_status(input logic busy, input logic latch,
                                             input logic efail, input logic pfail,
                                             input logic [1:0] ecc);
    return {2'b00, ecc, pfail, efail, latch, busy};
  endfunction

  // byte returned at position pos of an identification frame
  function automatic logic [7:0] id_reply(input logic [7:0] pos, input logic high_cap);
    case (pos)
      8'd2:    return MFR_CODE;
      8'd3:    return high_cap ? CAP_2G : CAP_1G;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_array_op(input logic [7:0] op);
    return (op == OP_ERASE) || (op == OP_PROG_EXEC) || (op == OP_PAGE_READ);
  endfunction

  function automatic logic needs_latch(input logic [7:0] op);
    return (op == OP_ERASE) || (op == OP_PROG_EXEC);
  endfunction

endpackage

// File: rtl/nand_spi_front.sv
module nand_spi_front #(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [7:0]       tx_byte,
  output logic             cs_act,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] rx_idx,
  output logic             miso
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [SYNC_STAGES:0]   sck_sh;
  logic [SYNC_STAGES-1:0] cs_sh;
  logic [SYNC_STAGES-1:0] mosi_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh  <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[SYNC_STAGES-1:0], sck};
      cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sck_now, sck_old, mosi_s, sck_rise, sck_fall;
  assign sck_now  = sck_sh[SYNC_STAGES-1];
  assign sck_old  = sck_sh[SYNC_STAGES];
  assign mosi_s   = mosi_sh[SYNC_STAGES-1];
  assign cs_act   = ~cs_sh[SYNC_STAGES-1];
  assign sck_rise = sck_now & ~sck_old;
  assign sck_fall = ~sck_now & sck_old;

  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      rx_idx    <= '0;
      miso_q    <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        miso_q   <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= {shreg[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {shreg, mosi_s};
            rx_idx    <= byte_idx;
            byte_idx  <= (byte_idx == IDX_MAX) ? IDX_MAX : byte_idx + 1'b1;
          end
        end
        if (sck_fall) begin
          miso_q <= tx_byte[3'd7 - bit_cnt];
        end
      end
    end
  end

  assign miso = miso_q;

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import spi_nand_pkg::*;
#(
  parameter bit HIGH_CAP = 1'b0,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic             oip,
  input  logic             wel,
  input  logic [7:0]       cfg_val,
  input  logic [7:0]       prot_val,
  input  logic [7:0]       stat_val,
  output logic [7:0]       tx_byte,
  output logic             wren_stb,
  output logic             wrdi_stb,
  output logic             reset_stb,
  output logic             feat_wr_stb,
  output logic [7:0]       feat_addr,
  output logic [7:0]       feat_data,
  output logic             arr_launch,
  output logic             arr_is_wr
);

  logic [7:0] op_q, addr_q;
  logic       acc_q;

  logic at0, at1, at2, at3;
  assign at0 = byte_done && (rx_idx == IDX_W'(0));
  assign at1 = byte_done && (rx_idx == IDX_W'(1));
  assign at2 = byte_done && (rx_idx == IDX_W'(2));
  assign at3 = byte_done && (rx_idx == IDX_W'(3));

  // commands other than status polling and reset are refused while busy
  logic accept_now;
  assign accept_now = !oip || (rx_byte == OP_GET_FEAT) || (rx_byte == OP_RESET);

  assign wren_stb    = at0 && accept_now && (rx_byte == OP_WREN);
  assign wrdi_stb    = at0 && accept_now && (rx_byte == OP_WRDI);
  assign reset_stb   = at0 && (rx_byte == OP_RESET);
  assign feat_wr_stb = at2 && acc_q && !oip && (op_q == OP_SET_FEAT);
  assign feat_addr   = addr_q;
  assign feat_data   = rx_byte;
  assign arr_is_wr   = needs_latch(op_q);
  assign arr_launch  = at3 && acc_q && !oip && is_array_op(op_q) &&
                       (!needs_latch(op_q) || wel);

  function automatic logic [7:0] feat_read(input logic [7:0] a);
    case (a)
      FA_CFG:  return cfg_val;
      FA_STAT: return stat_val;
      FA_PROT: return prot_val;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0]       cur_op, cur_addr, next_tx;
  logic             cur_acc;
  logic [IDX_W-1:0] nxt_pos;

  assign cur_op   = at0 ? rx_byte : op_q;
  assign cur_acc  = at0 ? accept_now : acc_q;
  assign cur_addr = at1 ? rx_byte : addr_q;
  assign nxt_pos  = rx_idx + 1'b1;

  always_comb begin
    next_tx = 8'h00;
    if (cur_acc) begin
      if ((cur_op == OP_GET_FEAT) && (rx_idx != IDX_W'(0))) begin
        next_tx = feat_read(cur_addr);
      end else if (cur_op == OP_READ_ID) begin
        next_tx = id_reply(8'(nxt_pos), HIGH_CAP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      acc_q   <= 1'b0;
      tx_byte <= '0;
    end else if (!cs_act) begin
      op_q    <= '0;
      acc_q   <= 1'b0;
      tx_byte <= '0;
    end else if (byte_done) begin
      if (at0) begin
        op_q  <= rx_byte;
        acc_q <= accept_now;
      end
      if (at1) begin
        addr_q <= rx_byte;
      end
      tx_byte <= next_tx;
    end
  end

endmodule

// File: rtl/nand_feature_regs.sv
module nand_feature_regs
  import spi_nand_pkg::*;
#(
  parameter int BUSY_W       = 16,
  parameter int RESET_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              reset_stb,
  input  logic              feat_wr_stb,
  input  logic [7:0]        feat_addr,
  input  logic [7:0]        feat_data,
  input  logic              arr_launch,
  input  logic              arr_is_wr,
  input  logic [BUSY_W-1:0] busy_cycles,
  output logic [7:0]        cfg_val,
  output logic [7:0]        prot_val,
  output logic [7:0]        stat_val,
  output logic              oip,
  output logic              wel,
  output logic              op_done,
  output logic              done_was_wr
);

  localparam int                RST_N    = (RESET_CYCLES < 1) ? 1 : RESET_CYCLES;
  localparam logic [BUSY_W-1:0] RST_LOAD = RST_N[BUSY_W-1:0];
  localparam logic [BUSY_W-1:0] ONE      = BUSY_W'(1);

  function automatic logic [BUSY_W-1:0] clamp_load(input logic [BUSY_W-1:0] n);
    return (n == '0) ? ONE : n;
  endfunction

  logic [BUSY_W-1:0] cnt;
  logic              kind_wr;

  assign op_done     = oip && (cnt == ONE);
  assign done_was_wr = op_done && kind_wr;
  assign stat_val    = pack_status(oip, wel, 1'b0, 1'b0, 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_val  <= CFG_RST;
      prot_val <= PROT_RST;
      wel      <= 1'b0;
      oip      <= 1'b0;
      cnt      <= '0;
      kind_wr  <= 1'b0;
    end else if (reset_stb) begin
      wel     <= 1'b0;
      oip     <= 1'b1;
      cnt     <= RST_LOAD;
      kind_wr <= 1'b0;
    end else begin
      if (op_done) begin
        oip <= 1'b0;
        cnt <= '0;
        if (kind_wr) wel <= 1'b0;
      end else if (oip) begin
        cnt <= cnt - ONE;
      end
      if (arr_launch) begin
        oip     <= 1'b1;
        cnt     <= clamp_load(busy_cycles);
        kind_wr <= arr_is_wr;
      end
      if (wren_stb) wel <= 1'b1;
      if (wrdi_stb) wel <= 1'b0;
      if (feat_wr_stb) begin
        case (feat_addr)
          FA_CFG: cfg_val <= feat_data & CFG_WMASK;
          FA_PROT: begin
            if (!prot_val[PROT_LOCK]) prot_val <= feat_data & PROT_WMASK;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_nand_responder.sv
module spi_nand_responder #(
  parameter bit HIGH_CAP     = 1'b0,
  parameter int BUSY_W       = 16,
  parameter int RESET_CYCLES = 40,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUSY_W-1:0] busy_cycles,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso
);

  localparam int IDX_W = 3;

  logic             cs_act, byte_done;
  logic [7:0]       rx_byte, tx_byte;
  logic [IDX_W-1:0] rx_idx;
  logic             wren_stb, wrdi_stb, reset_stb, feat_wr_stb;
  logic [7:0]       feat_addr, feat_data;
  logic             arr_launch, arr_is_wr;
  logic [7:0]       cfg_val, prot_val, stat_val;
  logic             oip, wel, op_done, done_was_wr;

  nand_spi_front #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .rx_idx(rx_idx), .miso(miso)
  );

  nand_cmd_decoder #(.HIGH_CAP(HIGH_CAP), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .rx_idx(rx_idx), .oip(oip), .wel(wel),
    .cfg_val(cfg_val), .prot_val(prot_val), .stat_val(stat_val),
    .tx_byte(tx_byte), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .reset_stb(reset_stb), .feat_wr_stb(feat_wr_stb), .feat_addr(feat_addr),
    .feat_data(feat_data), .arr_launch(arr_launch), .arr_is_wr(arr_is_wr)
  );

  nand_feature_regs #(.BUSY_W(BUSY_W), .RESET_CYCLES(RESET_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .reset_stb(reset_stb), .feat_wr_stb(feat_wr_stb), .feat_addr(feat_addr),
    .feat_data(feat_data), .arr_launch(arr_launch), .arr_is_wr(arr_is_wr),
    .busy_cycles(busy_cycles), .cfg_val(cfg_val), .prot_val(prot_val),
    .stat_val(stat_val), .oip(oip), .wel(wel), .op_done(op_done),
    .done_was_wr(done_was_wr)
  );

endmodule

// File: rtl/nand_resp_checker.sv
module nand_resp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       miso,
  input logic       byte_done,
  input logic       arr_launch,
  input logic       reset_stb,
  input logic       oip,
  input logic       wel,
  input logic       op_done,
  input logic       done_was_wr,
  input logic [7:0] prot_val
);

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);  // R1

  AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !byte_done);  // R11

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_launch |=> oip);  // R8

  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done_was_wr |=> !wel);  // R8

  AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_stb |=> (oip && !wel));  // R7

  AST_BUSY_WEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oip && !op_done && !reset_stb) |=> $stable(wel));  // R9

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    prot_val[7] |=> $stable(prot_val));  // R10

endmodule

bind spi_nand_responder nand_resp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso(miso),
  .byte_done(byte_done), .arr_launch(arr_launch), .reset_stb(reset_stb),
  .oip(oip), .wel(wel), .op_done(op_done), .done_was_wr(done_was_wr),
  .prot_val(prot_val)
);

// File: tb/tb_spi_nand_responder.sv
module tb_spi_nand_responder;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busy_cycles = 16'd3000;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  spi_nand_responder #(.RESET_CYCLES(600)) dut (
    .clk(clk), .rst_n(rst_n), .busy_cycles(busy_cycles),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // set-feature address, data, expected get-feature readback
  localparam logic [23:0] VEC [7] = '{
    {8'hB0, 8'hFF, 8'hD1},
    {8'hB0, 8'h00, 8'h00},
    {8'hB0, 8'h10, 8'h10},
    {8'hC0, 8'hFF, 8'h00},
    {8'hA0, 8'h00, 8'h00},
    {8'hA0, 8'h7F, 8'h3F},
    {8'h55, 8'hFF, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic open_cs();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic close_cs();
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    open_cs(); xfer(op, d); close_cs();
  endtask

  task automatic get_feat(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] d;
    open_cs(); xfer(8'h0F, d); xfer(a, d); xfer(8'h00, v); close_cs();
  endtask

  task automatic set_feat(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] d;
    open_cs(); xfer(8'h1F, d); xfer(a, d); xfer(v, d); close_cs();
  endtask

  task automatic arr_cmd(input logic [7:0] op);
    logic [7:0] d;
    open_cs(); xfer(op, d); xfer(8'h00, d); xfer(8'h01, d); xfer(8'h40, d); close_cs();
  endtask

  task automatic poll_idle(output int polls, output logic [7:0] last);
    polls = 0;
    last  = 8'hFF;
    for (int k = 0; k < 40; k++) begin
      get_feat(8'hC0, last);
      polls++;
      if (!last[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, a, b, d;
    int polls;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R12 reset state, R1 quiet output
    chk("R1 miso low while deselected", 32'(miso), 32'h0);
    get_feat(8'hB0, v); chk("R12 config default", 32'(v), 32'h10);
    get_feat(8'hA0, v); chk("R12 protect default", 32'(v), 32'h38);
    get_feat(8'hC0, v); chk("R12 R4 status default", 32'(v), 32'h00);

    // R2 R3 feature table
    for (int k = 0; k < 7; k++) begin
      set_feat(VEC[k][23:16], VEC[k][15:8]);
      get_feat(VEC[k][23:16], v);
      chk($sformatf("R2 R3 vector %0d", k), 32'(v), 32'(VEC[k][7:0]));
    end

    // R6 identification, also R1 bit order
    open_cs();
    xfer(8'h9F, d); xfer(8'h00, a); xfer(8'h00, b); xfer(8'h00, v); xfer(8'h00, d);
    close_cs();
    chk("R6 dummy byte", 32'(a), 32'h00);
    chk("R6 R1 manufacturer", 32'(b), 32'hC2);
    chk("R6 capacity", 32'(v), 32'h12);
    chk("R6 trailing byte", 32'(d), 32'h00);

    // R5 latch set and clear
    cmd1(8'h06);
    get_feat(8'hC0, v); chk("R5 R4 latch set", 32'(v), 32'h02);

    // R2 repeated reads in one frame
    open_cs(); xfer(8'h0F, d); xfer(8'hC0, d); xfer(8'h00, a); xfer(8'h00, b); close_cs();
    chk("R2 first repeat", 32'(a), 32'h02);
    chk("R2 second repeat", 32'(b), 32'h02);

    cmd1(8'h04);
    get_feat(8'hC0, v); chk("R5 latch cleared", 32'(v), 32'h00);

    // R11 abandoned set-feature and partial byte
    open_cs(); xfer(8'h1F, d); xfer(8'hB0, d); close_cs();
    get_feat(8'hB0, v); chk("R11 aborted write", 32'(v), 32'h10);
    open_cs();
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    close_cs();
    cmd1(8'h06);
    get_feat(8'hC0, v); chk("R11 framing restart", 32'(v), 32'h02);
    cmd1(8'h04);

    // R8 erase refused without latch
    arr_cmd(8'hD8);
    get_feat(8'hC0, v); chk("R8 erase without latch", 32'(v), 32'h00);

    // R8 R9 erase with latch
    cmd1(8'h06);
    arr_cmd(8'hD8);
    set_feat(8'hB0, 8'h00);
    get_feat(8'hC0, v); chk("R8 erase busy", 32'(v), 32'h03);
    poll_idle(polls, v);
    chk("R8 erase clears latch", 32'(v), 32'h00);
    chk("R8 busy duration", 32'(polls >= 6), 32'h1);
    get_feat(8'hB0, v); chk("R9 write while busy ignored", 32'(v), 32'h10);

    // R8 zero duration
    busy_cycles = 16'd0;
    cmd1(8'h06);
    arr_cmd(8'h10);
    get_feat(8'hC0, v); chk("R8 minimum duration", 32'(v), 32'h00);
    busy_cycles = 16'd3000;

    // R8 R9 page read keeps latch, disable ignored while busy
    cmd1(8'h06);
    arr_cmd(8'h13);
    cmd1(8'h04);
    get_feat(8'hC0, v); chk("R9 page read busy", 32'(v), 32'h03);
    poll_idle(polls, v);
    chk("R8 page read keeps latch", 32'(v), 32'h02);

    // R7 reset during program
    arr_cmd(8'h10);
    cmd1(8'hFF);
    get_feat(8'hC0, v); chk("R7 reset busy", 32'(v), 32'h01);
    poll_idle(polls, v);
    chk("R7 reset idle", 32'(v), 32'h00);
    chk("R7 reset cancels program", 32'(polls <= 4), 32'h1);

    // R10 lock lands with its own write
    set_feat(8'hA0, 8'hB8);
    get_feat(8'hA0, v); chk("R10 locking write stored", 32'(v), 32'hB8);
    set_feat(8'hA0, 8'h00);
    get_feat(8'hA0, v); chk("R10 locked", 32'(v), 32'hB8);

    tick(20);
    finish_run();
  end

endmodule